// File: doc/BRIEF.md
# Transmit Completion Status Queue

This block keeps a short first-in, first-out record of how each transmitted frame ended. The transmit MAC pulses a completion strobe once per finished frame and supplies its outcome flags: interrupt-on-success requested, jabber, underrun and collision limit reached. The block turns these flags into one status byte. The host always sees the oldest byte that it has not yet consumed. The host consumes a byte by writing to the status port, not by reading it. The block therefore gets a pop strobe and ignores the write data.

The queue holds a fixed number of entries. A completion that arrives while the queue is full is dropped. Its loss is recorded in the newest stored byte, so the host learns that something went missing. A jabber or underrun outcome stops the transmitter until a transmit reset. The transmit reset also empties the queue. A level event output asks for host attention while the oldest entry reports an error or a requested interrupt.

Top module: `txc_stat_queue`

## Requirements
- R1: A stored byte has bit 7 = 1 (complete), bit 6 = interrupt requested, bit 5 = jabber, bit 4 = underrun, bit 3 = collision limit reached, bit 2 = overflow (0 when stored), and bits 1:0 = 0.
- R2: `stat_byte_o` shows the oldest stored entry. An entry pushed at a clock edge with `cmp_valid_i` high is visible after that edge if the queue was empty.
- R3: A `host_pop_i` pulse on a non-empty queue removes the oldest entry. The next entry, or 0, appears after that edge.
- R4: The queue holds DEPTH entries (default 4). A completion that arrives while the queue is full and no pop happens in the same cycle is dropped, and bit 2 of the newest stored entry is set.
- R5: An empty queue reads 0. A pop on an empty queue changes nothing.
- R6: With the queue full, a pop and a completion in the same cycle are both carried out, and no overflow is marked.
- R7: A completion with jabber or underrun drives `tx_ok_o` low from the next cycle, whether or not the entry is stored. `tx_ok_o` stays low until a transmit reset.
- R8: `tx_reset_i` empties the queue and sets `tx_ok_o` high. It overrides a completion or a pop in the same cycle.
- R9: `txc_event_o` is high exactly while the queue is non-empty and the oldest entry has bit 6 set or any of bits 5..2 set.
- R10: While `rst_n` is low at a clock edge, the queue empties, `tx_ok_o` goes high and `txc_event_o` goes low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmp_valid_i | input | 1 | One-cycle strobe: a frame has finished |
| cmp_irq_req_i | input | 1 | The finished frame asked for an interrupt on success |
| cmp_jabber_i | input | 1 | The finished frame ended in jabber |
| cmp_underrun_i | input | 1 | The finished frame ended in underrun |
| cmp_max_coll_i | input | 1 | The finished frame hit the collision limit |
| host_pop_i | input | 1 | Host write to the status port; removes the oldest entry |
| tx_reset_i | input | 1 | Transmit reset command |
| stat_byte_o | output | 8 | Oldest status byte, or 0 when empty |
| tx_ok_o | output | 1 | Transmitter may run |
| txc_event_o | output | 1 | Completion event for the host |

## Verification
The bench drives a table of stimulus vectors through the queue. The patterns are a plain completion, one with an interrupt request, and one per error flag: this shows that each flag lands on its own bit and that only the right ones raise the event. The table fills the queue until completions overflow, which separates dropping a completion from overwriting an entry and from marking the wrong entry. It also fills the queue and then pops and pushes in the same cycle, which separates ordering mistakes from overflow mistakes. Directed steps pop an empty queue, fault the transmitter and then use the transmit reset and the main reset, which shows whether the reset priorities hold.

// File: rtl/txc_stat_pkg.sv
// Package: status byte layout shared by the transmit completion queue.
// Assumes an 8-bit status byte whose bit positions are fixed by the host
// software that decodes it.
package txc_stat_pkg;

    localparam int STAT_W   = 8;
    localparam int BIT_DONE = 7;
    localparam int BIT_IRQ  = 6;
    localparam int BIT_JAB  = 5;
    localparam int BIT_UND  = 4;
    localparam int BIT_MAXC = 3;
    localparam int BIT_OVF  = 2;

    typedef struct packed {
        logic irq_req;
        logic jabber;
        logic underrun;
        logic max_coll;
    } txc_flags_t;

endpackage

// File: rtl/txc_entry_pack.sv
// Module: packs the MAC outcome flags into one status byte.
// Assumes that the overflow bit always starts at zero; the queue sets it later.
module txc_entry_pack
    import txc_stat_pkg::*;
(
    input  txc_flags_t          flags_i,
    output logic [STAT_W-1:0]   entry_o
);

    // Place each flag on its bit; bits below the overflow bit stay zero.
    always_comb begin
        entry_o           = '0;
        entry_o[BIT_DONE] = 1'b1;
        entry_o[BIT_IRQ]  = flags_i.irq_req;
        entry_o[BIT_JAB]  = flags_i.jabber;
        entry_o[BIT_UND]  = flags_i.underrun;
        entry_o[BIT_MAXC] = flags_i.max_coll;
    end

endmodule

// File: rtl/txc_stat_fifo.sv
// Module: circular store of status bytes with overflow marking.
// Assumes single-cycle push and pop strobes. clr_i takes priority over both.
// A push into a full store without a pop sets OVF_BIT of the newest slot.
module txc_stat_fifo #(
    parameter int DEPTH   = 4,
    parameter int W       = 8,
    parameter int OVF_BIT = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr_i,
    input  logic         push_i,
    input  logic [W-1:0] din_i,
    input  logic         pop_i,
    output logic [W-1:0] head_o,
    output logic         empty_o,
    output logic         full_o
);

    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);
    localparam logic [PTR_W-1:0] LAST     = PTR_W'(DEPTH - 1);
    localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);

    logic [W-1:0]     slot_q [DEPTH];
    logic [PTR_W-1:0] rd_q, wr_q, newest;
    logic [CNT_W-1:0] cnt_q;
    logic             pop_eff, push_eff, mark_ovf;

    function automatic logic [PTR_W-1:0] step(input logic [PTR_W-1:0] p);
        return (p == LAST) ? '0 : p + 1'b1;
    endfunction

    // Decode the occupancy flags and which operations take effect this cycle.
    always_comb begin
        empty_o  = (cnt_q == '0);
        full_o   = (cnt_q == FULL_CNT);
        pop_eff  = pop_i && !clr_i && !empty_o;
        push_eff = push_i && !clr_i && (!full_o || pop_eff);
        mark_ovf = push_i && !clr_i && full_o && !pop_eff;
        newest   = (wr_q == '0) ? LAST : wr_q - 1'b1;
        head_o   = empty_o ? '0 : slot_q[rd_q];
    end

    // Slot storage: write on push, set the overflow bit on a dropped push.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) slot_q[i] <= '0;
        end else if (push_eff) begin
            slot_q[wr_q] <= din_i;
        end else if (mark_ovf) begin
            slot_q[newest][OVF_BIT] <= 1'b1;
        end
    end

    // Pointers and occupancy count.
    always_ff @(posedge clk) begin
        if (!rst_n || clr_i) begin
            rd_q  <= '0;
            wr_q  <= '0;
            cnt_q <= '0;
        end else begin
            if (pop_eff)  rd_q <= step(rd_q);
            if (push_eff) wr_q <= step(wr_q);
            cnt_q <= cnt_q + CNT_W'(push_eff) - CNT_W'(pop_eff);
        end
    end

    p_count_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= FULL_CNT);

    p_full_drop_r4: assert property (@(posedge clk) disable iff (!rst_n)
        full_o && push_i && !pop_i && !clr_i |=> full_o && $stable(wr_q));

    p_pop_empty_r5: assert property (@(posedge clk) disable iff (!rst_n)
        empty_o && pop_i && !push_i && !clr_i |=> empty_o);

    p_swap_full_r6: assert property (@(posedge clk) disable iff (!rst_n)
        full_o && push_i && pop_i && !clr_i |=> full_o && !$stable(wr_q));

    p_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> empty_o);

endmodule

// File: rtl/txc_tx_gate.sv
// Module: holds the transmitter-enable state.
// Assumes fault_i is a one-cycle indication of a jabber or underrun outcome.
// Only clr_i (transmit reset) or the main reset turns the transmitter back on.
module txc_tx_gate (
    input  logic clk,
    input  logic rst_n,
    input  logic clr_i,
    input  logic fault_i,
    output logic tx_ok_o
);

    // Enable flag: cleared by a fault, restored by a transmit reset.
    always_ff @(posedge clk) begin
        if (!rst_n || clr_i) tx_ok_o <= 1'b1;
        else if (fault_i)    tx_ok_o <= 1'b0;
    end

    p_fault_blocks_r7: assert property (@(posedge clk) disable iff (!rst_n)
        fault_i && !clr_i |=> !tx_ok_o);

    p_stays_off_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !tx_ok_o && !clr_i |=> !tx_ok_o);

    p_reset_on_r8: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> tx_ok_o);

endmodule

// File: rtl/txc_evt_detect.sv
// Module: decides whether the oldest status byte needs host attention.
// Assumes that an empty store presents an all-zero byte.
module txc_evt_detect
    import txc_stat_pkg::*;
(
    input  logic [STAT_W-1:0] head_i,
    output logic              evt_o
);

    // Attention when the entry is complete and reports an error or a request.
    always_comb begin
        evt_o = head_i[BIT_DONE] &&
                (head_i[BIT_IRQ] || (|head_i[BIT_JAB:BIT_OVF]));
    end

endmodule

// File: rtl/txc_stat_queue.sv
// Module: transmit completion status queue (top).
// Assumes one completion strobe per frame and one host write per consumed entry.
// Joins the byte packer, the store, the transmitter gate and the event decoder.
module txc_stat_queue
    import txc_stat_pkg::*;
#(
    parameter int DEPTH = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmp_valid_i,
    input  logic              cmp_irq_req_i,
    input  logic              cmp_jabber_i,
    input  logic              cmp_underrun_i,
    input  logic              cmp_max_coll_i,
    input  logic              host_pop_i,
    input  logic              tx_reset_i,
    output logic [STAT_W-1:0] stat_byte_o,
    output logic              tx_ok_o,
    output logic              txc_event_o
);

    txc_flags_t          flags;
    logic [STAT_W-1:0]   new_entry;
    logic                fifo_empty, fifo_full;
    logic                fault;

    // Gather the outcome flags and detect a transmitter-stopping fault.
    always_comb begin
        flags.irq_req  = cmp_irq_req_i;
        flags.jabber   = cmp_jabber_i;
        flags.underrun = cmp_underrun_i;
        flags.max_coll = cmp_max_coll_i;
        fault          = cmp_valid_i && (cmp_jabber_i || cmp_underrun_i);
    end

    txc_entry_pack pack_i (
        .flags_i (flags),
        .entry_o (new_entry)
    );

    txc_stat_fifo #(
        .DEPTH   (DEPTH),
        .W       (STAT_W),
        .OVF_BIT (BIT_OVF)
    ) fifo_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr_i   (tx_reset_i),
        .push_i  (cmp_valid_i),
        .din_i   (new_entry),
        .pop_i   (host_pop_i),
        .head_o  (stat_byte_o),
        .empty_o (fifo_empty),
        .full_o  (fifo_full)
    );

    txc_tx_gate gate_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr_i   (tx_reset_i),
        .fault_i (fault),
        .tx_ok_o (tx_ok_o)
    );

    txc_evt_detect evt_i (
        .head_i (stat_byte_o),
        .evt_o  (txc_event_o)
    );

    p_empty_reads_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_empty |-> stat_byte_o == '0);

    p_event_needs_entry_r9: assert property (@(posedge clk) disable iff (!rst_n)
        txc_event_o |-> !fifo_empty && stat_byte_o[BIT_DONE]);

    p_low_bits_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
        stat_byte_o[1:0] == 2'b00);

    p_full_flag_r4: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_full |-> !fifo_empty);

endmodule

// File: tb/txc_stat_queue_tb_top.sv
`timescale 1ns/1ps
module txc_stat_queue_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cmp_valid = 1'b0, cmp_irq = 1'b0, cmp_jab = 1'b0;
    logic       cmp_und = 1'b0, cmp_mc = 1'b0, pop = 1'b0, txrst = 1'b0;
    logic [7:0] stat_byte;
    logic       tx_ok, evt;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    txc_stat_queue #(.DEPTH(4)) dut_i (
        .clk            (clk),
        .rst_n          (rst_n),
        .cmp_valid_i    (cmp_valid),
        .cmp_irq_req_i  (cmp_irq),
        .cmp_jabber_i   (cmp_jab),
        .cmp_underrun_i (cmp_und),
        .cmp_max_coll_i (cmp_mc),
        .host_pop_i     (pop),
        .tx_reset_i     (txrst),
        .stat_byte_o    (stat_byte),
        .tx_ok_o        (tx_ok),
        .txc_event_o    (evt)
    );

    // Vector: {req tag, push irq jab und mc pop txrst, expected byte, ok, evt}
    localparam int NV = 31;
    localparam logic [20:0] VEC [NV] = '{
        {4'd2, 7'b1000000, 8'h80, 2'b10},
        {4'd1, 7'b1100000, 8'h80, 2'b10},
        {4'd3, 7'b0000010, 8'hC0, 2'b11},
        {4'd1, 7'b1000100, 8'hC0, 2'b11},
        {4'd3, 7'b0000010, 8'h88, 2'b11},
        {4'd3, 7'b0000010, 8'h00, 2'b10},
        {4'd5, 7'b0000010, 8'h00, 2'b10},
        {4'd2, 7'b1000000, 8'h80, 2'b10},
        {4'd2, 7'b1000000, 8'h80, 2'b10},
        {4'd2, 7'b1100000, 8'h80, 2'b10},
        {4'd2, 7'b1000100, 8'h80, 2'b10},
        {4'd4, 7'b1100000, 8'h80, 2'b10},
        {4'd3, 7'b0000010, 8'h80, 2'b10},
        {4'd3, 7'b0000010, 8'hC0, 2'b11},
        {4'd4, 7'b0000010, 8'h8C, 2'b11},
        {4'd3, 7'b0000010, 8'h00, 2'b10},
        {4'd2, 7'b1000000, 8'h80, 2'b10},
        {4'd2, 7'b1000000, 8'h80, 2'b10},
        {4'd2, 7'b1000000, 8'h80, 2'b10},
        {4'd2, 7'b1000000, 8'h80, 2'b10},
        {4'd6, 7'b1100010, 8'h80, 2'b10},
        {4'd3, 7'b0000010, 8'h80, 2'b10},
        {4'd3, 7'b0000010, 8'h80, 2'b10},
        {4'd6, 7'b0000010, 8'hC0, 2'b11},
        {4'd1, 7'b1010000, 8'hC0, 2'b01},
        {4'd3, 7'b0000010, 8'hA0, 2'b01},
        {4'd8, 7'b1000011, 8'h00, 2'b10},
        {4'd1, 7'b1001000, 8'h90, 2'b01},
        {4'd2, 7'b1000000, 8'h90, 2'b01},
        {4'd8, 7'b0000001, 8'h00, 2'b10},
        {4'd2, 7'b1000000, 8'h80, 2'b10}
    };

    function automatic string rtag(input int n);
        case (n)
            1: return "R1";
            2: return "R2";
            3: return "R3";
            4: return "R4";
            5: return "R5";
            6: return "R6";
            8: return "R8";
            default: return "R?";
        endcase
    endfunction

    task automatic check(input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic drive(input logic [6:0] s);
        {cmp_valid, cmp_irq, cmp_jab, cmp_und, cmp_mc, pop, txrst} = s;
    endtask

    task automatic step_and_sample();
        @(posedge clk);
        @(negedge clk);
        drive(7'b0);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    initial begin
        repeat (5000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual running expected finished");
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        // R10: state after reset
        check("R10", "reset byte", stat_byte, 8'h00);
        check("R10", "reset tx_ok", tx_ok, 1);
        check("R10", "reset event", evt, 0);

        for (int i = 0; i < NV; i++) begin
            drive(VEC[i][16:10]);
            step_and_sample();
            check(rtag(int'(VEC[i][20:17])), $sformatf("byte v%0d", i),
                  stat_byte, VEC[i][9:2]);
            check("R7", $sformatf("tx_ok v%0d", i), tx_ok, VEC[i][1]);
            check("R9", $sformatf("event v%0d", i), evt, VEC[i][0]);
        end

        // R8: transmit reset beats a same-cycle jabber completion.
        drive(7'b1010001);
        step_and_sample();
        check("R8", "clr vs jabber byte", stat_byte, 8'h00);
        check("R8", "clr vs jabber tx_ok", tx_ok, 1);

        // R5: pop on empty, then a completion still lands correctly.
        drive(7'b0000010);
        step_and_sample();
        check("R5", "pop empty byte", stat_byte, 8'h00);
        drive(7'b1000100);
        step_and_sample();
        check("R5", "push after empty pop", stat_byte, 8'h88);
        check("R9", "event max coll", evt, 1);

        // R7: a dropped completion with underrun still stops the transmitter.
        for (int k = 0; k < 3; k++) begin
            drive(7'b1000000);
            step_and_sample();
        end
        drive(7'b1001000);
        step_and_sample();
        check("R7", "full underrun tx_ok", tx_ok, 0);
        check("R4", "full underrun head", stat_byte, 8'h88);

        // R10: main reset empties the queue and re-enables the transmitter.
        rst_n = 1'b0;
        @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        check("R10", "reset byte again", stat_byte, 8'h00);
        check("R10", "reset tx_ok again", tx_ok, 1);
        check("R10", "reset event again", evt, 0);

        finish_run();
    end

endmodule